// File: doc/BRIEF.md
# Password Gate with Retry Wipe

This block decides whether a host may touch a protected serial memory. It keeps two 64-bit secrets, one that opens reads and one that opens writes and password changes. The host presents a command class together with an 8-byte entry. The block compares the entry with the secret that class needs. Every entry starts a forced nonvolatile busy period, whether or not it matched, which makes guessing slow. The verdict only becomes visible after that period, through a poll.

Mismatches against either secret advance one shared retry counter, and a match clears it. When the counter runs out, the block raises a wipe strobe so that the data array is erased, and it zeroes both secrets itself. A granted change-password session takes the new 8 bytes, runs its own busy period, and loads the value into the selected secret when that period ends. Bus framing, the storage array and the cell programming stay outside this block. The busy length is a parameter counted in clock cycles.

Top module: `pwd_guard`

## Requirements
- R1: After reset, `busy`, `granted`, `poll_ack` and `wipe` are low, and both secrets are all zeros, so an all-zero entry is accepted for any class.
- R2: `req_cmd` encodes 0 = sector write, 1 = sector read, 2 = change write secret, 3 = change read secret. Class 1 is compared with the read secret, and classes 0, 2 and 3 are compared with the write secret.
- R3: `granted` is high only after the busy period of an accepted entry that matched its secret has ended. It stays low after a mismatching entry.
- R4: An accepted entry (`req_valid` while `busy` is low) makes `busy` high for exactly BUSY_CYC cycles, starting in the cycle after the entry. This holds for matching and mismatching entries alike.
- R5: `poll_ack` is high in the cycle after a `poll` pulse only if `busy` was low and the last entry matched. A poll during busy is never acknowledged.
- R6: Each mismatch advances a shared 3-bit retry counter, and a match clears it. Seven consecutive mismatches followed by a match cause no wipe.
- R7: The eighth consecutive mismatch raises `wipe` for exactly one cycle, in the cycle after that entry. It zeroes both secrets and returns the counter to zero.
- R8: `new_valid` during a granted session of class 2 or 3, with `busy` low, starts a busy period of BUSY_CYC cycles and ends the grant. At the end of that period, `new_pw` is loaded into the selected secret, and the other secret is left unchanged.
- R9: `req_valid` or `new_valid` during busy is ignored, and `new_valid` is ignored without a granted change session. The counter, the secrets and the verdict are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle pulse presenting an entry |
| req_cmd | input | 2 | Command class of the entry |
| req_pw | input | 64 | Entered 8-byte password |
| poll | input | 1 | One-cycle verdict poll pulse |
| new_valid | input | 1 | One-cycle pulse presenting a new secret |
| new_pw | input | 64 | New 8-byte secret |
| busy | output | 1 | Nonvolatile busy period in progress |
| granted | output | 1 | Access granted and not busy |
| poll_ack | output | 1 | Registered answer to a poll |
| wipe | output | 1 | One-cycle request to erase the data array |

## Verification
The bench builds the block with BUSY_CYC = 5 and keeps the default 3-bit retry counter and 8-byte secrets. The short busy period brings the polls into range in a few cycles: polls during busy, polls right at its end, entries that land inside it, and the load of a changed secret. With the 3-bit counter, a full run of eight mismatches, the wipe that follows, and a run of seven mismatches followed by a match all fit within a few hundred cycles.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    CMD_WR_SECT = 2'd0,
    CMD_RD_SECT = 2'd1,
    CMD_CHG_WPW = 2'd2,
    CMD_CHG_RPW = 2'd3
  } pg_cmd_e;
endpackage

// File: rtl/pg_match.sv
module pg_match #(
  parameter int PW_W = 64
) (
  input  pg_pkg::pg_cmd_e  cmd,
  input  logic [PW_W-1:0]  entry,
  input  logic [PW_W-1:0]  rd_pw,
  input  logic [PW_W-1:0]  wr_pw,
  output logic             hit
);
  logic [PW_W-1:0] ref_pw;
  always_comb begin
    ref_pw = (cmd == pg_pkg::CMD_RD_SECT) ? rd_pw : wr_pw;
    hit    = (ref_pw == entry);
  end
endmodule

// File: rtl/pg_retry.sv
module pg_retry #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fail,
  input  logic pass,
  output logic exhaust
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  assign exhaust = fail && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (pass)    cnt_q <= '0;
    else if (exhaust) cnt_q <= '0;
    else if (fail)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pg_nvtimer.sv
module pg_nvtimer #(
  parameter int unsigned CYC = 2000000,
  localparam int W = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  logic [W-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (start) cnt_q <= W'(CYC);
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pwd_guard.sv
module pwd_guard #(
  parameter int PW_BYTES = 8,
  parameter int RETRY_W = 3,
  parameter int unsigned BUSY_CYC = 2000000,
  localparam int PW_W = PW_BYTES * 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_cmd,
  input  logic [PW_W-1:0] req_pw,
  input  logic            poll,
  input  logic            new_valid,
  input  logic [PW_W-1:0] new_pw,
  output logic            busy,
  output logic            granted,
  output logic            poll_ack,
  output logic            wipe
);
  import pg_pkg::*;

  pg_cmd_e         cmd_e, cls_q;
  logic [PW_W-1:0] rd_pw_q, wr_pw_q, new_q;
  logic            ok_q, pend_q, wipe_q, pack_q;
  logic            hit, busy_i, last_i, exhaust;
  logic            accept, fail, pass, chg_ok, start;

  assign cmd_e  = pg_cmd_e'(req_cmd);
  assign accept = req_valid && !busy_i;
  assign fail   = accept && !hit;
  assign pass   = accept && hit;
  assign chg_ok = !accept && new_valid && !busy_i && ok_q &&
                  ((cls_q == CMD_CHG_WPW) || (cls_q == CMD_CHG_RPW));
  assign start  = accept || chg_ok;

  pg_match #(.PW_W(PW_W)) u_match (
    .cmd(cmd_e), .entry(req_pw), .rd_pw(rd_pw_q), .wr_pw(wr_pw_q), .hit(hit)
  );

  pg_retry #(.CNT_W(RETRY_W)) u_retry (
    .clk(clk), .rst(rst), .fail(fail), .pass(pass), .exhaust(exhaust)
  );

  pg_nvtimer #(.CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy_i), .last(last_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pw_q <= '0;
      wr_pw_q <= '0;
      new_q   <= '0;
      ok_q    <= 1'b0;
      cls_q   <= CMD_WR_SECT;
      pend_q  <= 1'b0;
      wipe_q  <= 1'b0;
      pack_q  <= 1'b0;
    end else begin
      pack_q <= poll && !busy_i && ok_q;
      wipe_q <= fail && exhaust;
      if (accept) begin
        ok_q  <= hit;
        cls_q <= cmd_e;
      end else if (chg_ok) begin
        ok_q   <= 1'b0;
        pend_q <= 1'b1;
        new_q  <= new_pw;
      end
      if (fail && exhaust) begin
        rd_pw_q <= '0;
        wr_pw_q <= '0;
      end
      if (last_i && pend_q) begin
        pend_q <= 1'b0;
        if (cls_q == CMD_CHG_WPW) wr_pw_q <= new_q;
        else                      rd_pw_q <= new_q;
      end
    end
  end

  assign busy     = busy_i;
  assign granted  = ok_q && !busy_i;
  assign poll_ack = pack_q;
  assign wipe     = wipe_q;
endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic poll,
  input logic busy,
  input logic granted,
  input logic poll_ack,
  input logic wipe
);
  // R7
  wipe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |=> !wipe);
  // R5
  poll_gate_chk: assert property (@(posedge clk) disable iff (rst)
    poll_ack |-> ($past(poll) && !$past(busy)));
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);
  // R3
  grant_idle_chk: assert property (@(posedge clk) disable iff (rst)
    granted |-> !busy);
  // R7
  wipe_deny_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |-> (busy && !granted));
endmodule

bind pwd_guard pg_guard_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .poll(poll),
  .busy(busy), .granted(granted), .poll_ack(poll_ack), .wipe(wipe)
);

// File: tb/pwd_guard_test.sv
module pwd_guard_test;
  localparam int BUSY = 5;
  localparam logic [63:0] PW_A = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PW_B = 64'hFEED_FACE_CAFE_BEEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, poll = 1'b0, new_valid = 1'b0;
  logic [1:0]  req_cmd = 2'd0;
  logic [63:0] req_pw = '0, new_pw = '0;
  logic        busy, granted, poll_ack, wipe;

  int checks = 0, errors = 0, cyc = 0;
  bit armed = 0;

  always #2.5 clk = ~clk;

  pwd_guard #(.BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_pw(req_pw), .poll(poll), .new_valid(new_valid), .new_pw(new_pw),
    .busy(busy), .granted(granted), .poll_ack(poll_ack), .wipe(wipe)
  );

  // behavioural reference
  logic [63:0] m_rd, m_wr, m_new;
  int  m_cnt, m_left, m_cls;
  bit  m_ok, m_pend, m_wipe, m_pack;

  always @(posedge clk) begin
    if (rst) begin
      m_rd = 0; m_wr = 0; m_new = 0; m_cnt = 0; m_left = 0; m_cls = 0;
      m_ok = 0; m_pend = 0; m_wipe = 0; m_pack = 0;
    end else begin
      m_wipe = 0;
      m_pack = poll && (m_left == 0) && m_ok;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0 && m_pend) begin
          m_pend = 0;
          if (m_cls == 2) m_wr = m_new; else m_rd = m_new;
        end
      end else if (req_valid) begin
        bit match;
        match = (req_cmd == 2'd1) ? (m_rd == req_pw) : (m_wr == req_pw);
        m_ok = match; m_cls = req_cmd; m_left = BUSY;
        if (match) m_cnt = 0;
        else if (m_cnt == 7) begin
          m_cnt = 0; m_wipe = 1; m_rd = 0; m_wr = 0;
        end else m_cnt++;
      end else if (new_valid && m_ok && (m_cls >= 2)) begin
        m_pend = 1; m_new = new_pw; m_left = BUSY; m_ok = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (armed) begin
      chk("R4 busy", busy, m_left > 0);
      chk("R3 granted", granted, m_ok && m_left == 0);
      chk("R5 poll_ack", poll_ack, m_pack);
      chk("R7 wipe", wipe, m_wipe);
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic entry(input logic [1:0] c, input logic [63:0] p);
    req_valid = 1; req_cmd = c; req_pw = p;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_poll(output logic a);
    poll = 1;
    @(negedge clk);
    poll = 0;
    a = poll_ack;
  endtask

  task automatic chg(input logic [63:0] p);
    new_valid = 1; new_pw = p;
    @(negedge clk);
    new_valid = 0;
  endtask

  logic a;

  initial begin
    idle(3);
    rst = 0;
    armed = 1;
    chk("R1 busy", busy, 0); chk("R1 granted", granted, 0);
    chk("R1 wipe", wipe, 0); chk("R1 poll_ack", poll_ack, 0);
    // R1/R2: zero secrets, read class
    entry(2'd1, 64'd0);
    do_poll(a); chk("R5 poll while busy", a, 0);
    idle(BUSY);
    do_poll(a); chk("R1 zero read grant", a, 1);
    // R3: wrong write entry
    entry(2'd0, PW_A); idle(BUSY);
    do_poll(a); chk("R3 wrong denied", a, 0);
    // R8: change write secret
    entry(2'd2, 64'd0); idle(BUSY);
    chk("R8 change granted", granted, 1);
    chg(PW_A);
    chk("R8 busy after new", busy, 1);
    idle(BUSY);
    chk("R8 grant ended", granted, 0);
    entry(2'd0, 64'd0); idle(BUSY);
    chk("R8 old write secret gone", granted, 0);
    entry(2'd0, PW_A); idle(BUSY);
    chk("R8 new write secret", granted, 1);
    // R2: read secret independent
    entry(2'd1, 64'd0); idle(BUSY);
    chk("R2 read uses read secret", granted, 1);
    entry(2'd1, PW_A); idle(BUSY);
    chk("R2 read rejects write secret", granted, 0);
    entry(2'd3, PW_A); idle(BUSY);
    chk("R2 change-read uses write secret", granted, 1);
    chg(PW_B); idle(BUSY);
    entry(2'd1, PW_B); idle(BUSY);
    chk("R8 new read secret", granted, 1);
    // R9: entry during busy ignored
    entry(2'd0, PW_A);
    entry(2'd0, 64'hBAD);
    idle(BUSY);
    chk("R9 busy entry ignored", granted, 1);
    // R9: new secret without change session ignored
    chg(64'h1); idle(2);
    chk("R9 no-change-session ignored", busy, 0);
    entry(2'd0, PW_A); idle(BUSY);
    chk("R9 write secret kept", granted, 1);
    // R6: seven fails then match -> no wipe
    for (int i = 0; i < 7; i++) begin entry(2'd0, 64'hBAD); idle(BUSY); end
    entry(2'd1, PW_B); idle(BUSY);
    chk("R6 match clears counter", granted, 1);
    // R7: eight fails -> wipe
    for (int i = 0; i < 7; i++) begin entry(2'd1, 64'hBAD); idle(BUSY); end
    chk("R6 no early wipe", wipe, 0);
    entry(2'd0, 64'hBAD);
    chk("R7 wipe strobe", wipe, 1);
    idle(1);
    chk("R7 wipe one cycle", wipe, 0);
    idle(BUSY);
    entry(2'd0, 64'd0); idle(BUSY);
    chk("R7 write secret zeroed", granted, 1);
    entry(2'd1, 64'd0); idle(BUSY);
    chk("R7 read secret zeroed", granted, 1);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule